// File: doc/BRIEF.md
# Successive-approximation ADC sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. A one-cycle start request, taken together with a 3-bit channel number and a resolution choice, launches one conversion. The sequencer latches the channel onto the analog multiplexer select, spends an opening stretch of cycles letting the selected input settle, then walks the code from the most significant bit down. On each bit step it presents a trial code to the internal DAC and reads back a single comparator bit that says whether the input is at or above that trial level.

Two resolutions are offered. The full mode resolves 10 bits in 50 clock cycles; the fast mode resolves 8 bits in 24 clock cycles and writes only the upper result register. In full mode the top 8 result bits go to the upper register and the bottom 2 bits to a separate low field. A done flag marks a finished result and stays up until the next accepted start. While the system sits in idle, an idle power-down choice either lets the converter keep running or switches it off: its power enable drops and the sequence freezes until idle ends.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, busy_o, done_o, res_hi_o, res_lo_o, dac_code_o and mux_sel_o are all zero and pwr_en_o is one.
- R2: With fast_i low at the start, an input level V (0 to 1023, in DAC steps, comparator high when V >= dac_code_o) yields res_hi_o = V[9:2] and res_lo_o = V[1:0].
- R3: With fast_i high at the start, the result is res_hi_o = V[9:2] and res_lo_o keeps the value it had before that conversion.
- R4: busy_o is high for exactly 50 cycles (full mode) or 24 cycles (fast mode) after the clock edge that accepts a start, and done_o rises on the same edge on which busy_o falls.
- R5: The settling stretch comes first (40 cycles full, 16 cycles fast) with dac_code_o at zero; the bit steps follow MSB first, so the first bit step shows dac_code_o = 10'h200 in both modes.
- R6: mux_sel_o takes the value of chan_i at the accepting edge and holds it for the whole conversion, whatever chan_i does meanwhile.
- R7: done_o clears on the edge that accepts a start and otherwise stays set until then; done_o and busy_o are never high together.
- R8: A start request while busy_o is high is ignored: the running conversion's length, channel, mode and result are unchanged.
- R9: While idle_i and idle_pd_i are both high, pwr_en_o is low, a running conversion is frozen (each such cycle lengthens it by one and dac_code_o holds), and a start request is ignored.
- R10: While idle_i is high and idle_pd_i is low, pwr_en_o stays high and a conversion runs with its normal length and result.
- R11: The extreme inputs convert exactly: V = 0 gives all-zero fields and V = 1023 gives all-one fields in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when not busy and not powered down |
| chan_i | input | 3 | Channel number, latched at start |
| fast_i | input | 1 | 1 selects the 8-bit fast mode, latched at start |
| idle_i | input | 1 | System idle indication |
| idle_pd_i | input | 1 | 1 powers the converter down while idle |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| mux_sel_o | output | 3 | Analog multiplexer select |
| dac_code_o | output | 10 | Trial code to the internal DAC |
| pwr_en_o | output | 1 | Analog power enable |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Result valid since the last accepted start |
| res_hi_o | output | 8 | Upper result register |
| res_lo_o | output | 2 | Low result field (full mode only) |

## Verification
A wrong bit-position counter shows up at dac_code_o on the very first bit step, 40 or 16 cycles after the start, as a trial code other than 10'h200, and later as a wrong res_hi_o. A count that is off by one in either mode moves the falling edge of busy_o and the rise of done_o, which the bench sees as a wrong busy length the moment the conversion ends. A search register that keeps or drops a decision wrongly shows in the result fields as soon as done_o rises, and a mode or channel that leaks from a mid-conversion start shows as a different length, a changed mux select or a result taken from the wrong input.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   // Phase of the sequencer as seen by its sub-blocks
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETTLE = 2'd1,
      PH_STEP   = 2'd2
   } sar_phase_e;

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
   import sar_seq_pkg::*;
#(
   parameter int FULL_BITS   = 10,
   parameter int FAST_BITS   = 8,
   parameter int FULL_CYCLES = 50,
   parameter int FAST_CYCLES = 24
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         launch_i,
   input  logic                         fast_i,
   input  logic                         run_en_i,
   output logic                         busy_o,
   output sar_phase_e                   phase_o,
   output logic                         finish_o,
   output logic [$clog2(FULL_BITS)-1:0] bit_pos_o
);

   localparam int CNT_W   = $clog2(FULL_CYCLES);
   localparam int POS_W   = $clog2(FULL_BITS);
   localparam int LO_BITS = FULL_BITS - FAST_BITS;

   localparam logic [CNT_W-1:0] PRE_FULL  = CNT_W'(FULL_CYCLES - 1);
   localparam logic [CNT_W-1:0] PRE_FAST  = CNT_W'(FAST_CYCLES - 1);
   localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(FULL_BITS);
   localparam logic [CNT_W-1:0] BITS_FAST = CNT_W'(FAST_BITS);
   localparam logic [POS_W-1:0] POS_OFS   = POS_W'(LO_BITS);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic [CNT_W-1:0] preset;
   logic [CNT_W-1:0] nbits;
   logic             stepping;

   assign preset   = fast_i ? PRE_FAST  : PRE_FULL;
   assign nbits    = fast_i ? BITS_FAST : BITS_FULL;
   assign stepping = busy_q && (cnt_q < nbits);

   // Remaining-cycle counter: counts down to zero, the bit steps are the last nbits values
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (launch_i) begin
         busy_q <= 1'b1;
         cnt_q  <= preset;
      end else if (busy_q && run_en_i) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   always_comb begin
      if (!busy_q) begin
         phase_o = PH_IDLE;
      end else if (stepping) begin
         phase_o = PH_STEP;
      end else begin
         phase_o = PH_SETTLE;
      end
   end

   // In fast mode the search runs over the upper bits of the DAC code
   assign bit_pos_o = POS_W'(cnt_q) + (fast_i ? POS_OFS : '0);
   assign finish_o  = busy_q && run_en_i && (cnt_q == '0);
   assign busy_o    = busy_q;

endmodule

// File: rtl/sar_seq_search.sv
module sar_seq_search #(
   parameter int FULL_BITS = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear_i,
   input  logic                         show_i,
   input  logic                         decide_i,
   input  logic [$clog2(FULL_BITS)-1:0] bit_pos_i,
   input  logic                         cmp_i,
   output logic [FULL_BITS-1:0]         trial_o,
   output logic [FULL_BITS-1:0]         acc_next_o
);

   localparam int POS_W = $clog2(FULL_BITS);

   logic [FULL_BITS-1:0] acc_q;
   logic [FULL_BITS-1:0] mask;

   // One-hot trial bit for the position under test
   for (genvar gi = 0; gi < FULL_BITS; gi++) begin : g_mask
      assign mask[gi] = show_i && (bit_pos_i == POS_W'(gi));
   end

   assign trial_o    = acc_q | mask;
   // Keep the trial bit only when the input is at or above the trial level
   assign acc_next_o = (decide_i && cmp_i) ? trial_o : acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clear_i) begin
         acc_q <= '0;
      end else if (decide_i) begin
         acc_q <= acc_next_o;
      end
   end

endmodule

// File: rtl/sar_seq_result.sv
module sar_seq_result #(
   parameter int FULL_BITS = 10,
   parameter int FAST_BITS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clear_i,
   input  logic                           finish_i,
   input  logic                           fast_i,
   input  logic [FULL_BITS-1:0]           code_i,
   output logic                           done_o,
   output logic [FAST_BITS-1:0]           hi_o,
   output logic [FULL_BITS-FAST_BITS-1:0] lo_o
);

   localparam int LO_BITS = FULL_BITS - FAST_BITS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o <= 1'b0;
         hi_o   <= '0;
      end else if (clear_i) begin
         done_o <= 1'b0;
      end else if (finish_i) begin
         done_o <= 1'b1;
         hi_o   <= code_i[FULL_BITS-1 -: FAST_BITS];
      end
   end

   // Low field is written by full-resolution conversions only
   if (LO_BITS > 0) begin : g_lo
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_o <= '0;
         end else if (finish_i && !fast_i) begin
            lo_o <= code_i[LO_BITS-1:0];
         end
      end
   end

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
   import sar_seq_pkg::*;
#(
   parameter int FULL_BITS   = 10,
   parameter int FAST_BITS   = 8,
   parameter int CH_COUNT    = 8,
   parameter int FULL_CYCLES = 50,
   parameter int FAST_CYCLES = 24
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic [$clog2(CH_COUNT)-1:0]    chan_i,
   input  logic                           fast_i,
   input  logic                           idle_i,
   input  logic                           idle_pd_i,
   input  logic                           cmp_i,
   output logic [$clog2(CH_COUNT)-1:0]    mux_sel_o,
   output logic [FULL_BITS-1:0]           dac_code_o,
   output logic                           pwr_en_o,
   output logic                           busy_o,
   output logic                           done_o,
   output logic [FAST_BITS-1:0]           res_hi_o,
   output logic [FULL_BITS-FAST_BITS-1:0] res_lo_o
);

   localparam int CH_W    = $clog2(CH_COUNT);
   localparam int POS_W   = $clog2(FULL_BITS);
   localparam int LO_BITS = FULL_BITS - FAST_BITS;

   initial begin : g_param_chk
      assert (LO_BITS >= 1)
         else $error("fast resolution must be narrower than full resolution");
      assert (FULL_CYCLES > FULL_BITS && FAST_CYCLES > FAST_BITS)
         else $error("each mode needs at least one settling cycle");
      assert (FULL_CYCLES >= FAST_CYCLES)
         else $error("counter is sized from the full-mode cycle count");
      assert (CH_COUNT >= 2)
         else $error("multiplexer needs at least two inputs");
   end

   logic             run_en;
   logic             launch;
   logic             busy;
   logic             fast_q;
   logic             fast_eff;
   logic [CH_W-1:0]  chan_q;
   sar_phase_e       phase;
   logic             finish;
   logic [POS_W-1:0] bit_pos;
   logic             show;
   logic             decide;
   logic [FULL_BITS-1:0] trial;
   logic [FULL_BITS-1:0] acc_next;

   // Powered down only when idle and the power-down choice is set
   assign run_en   = !(idle_i && idle_pd_i);
   assign launch   = start_i && !busy && run_en;
   assign fast_eff = launch ? fast_i : fast_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q <= '0;
         fast_q <= 1'b0;
      end else if (launch) begin
         chan_q <= chan_i;
         fast_q <= fast_i;
      end
   end

   sar_seq_timer #(
      .FULL_BITS  (FULL_BITS),
      .FAST_BITS  (FAST_BITS),
      .FULL_CYCLES(FULL_CYCLES),
      .FAST_CYCLES(FAST_CYCLES)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch_i (launch),
      .fast_i   (fast_eff),
      .run_en_i (run_en),
      .busy_o   (busy),
      .phase_o  (phase),
      .finish_o (finish),
      .bit_pos_o(bit_pos)
   );

   assign show   = (phase == PH_STEP);
   assign decide = show && run_en;

   sar_seq_search #(
      .FULL_BITS(FULL_BITS)
   ) u_search (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (launch),
      .show_i    (show),
      .decide_i  (decide),
      .bit_pos_i (bit_pos),
      .cmp_i     (cmp_i),
      .trial_o   (trial),
      .acc_next_o(acc_next)
   );

   sar_seq_result #(
      .FULL_BITS(FULL_BITS),
      .FAST_BITS(FAST_BITS)
   ) u_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (launch),
      .finish_i(finish),
      .fast_i  (fast_q),
      .code_i  (acc_next),
      .done_o  (done_o),
      .hi_o    (res_hi_o),
      .lo_o    (res_lo_o)
   );

   assign mux_sel_o  = chan_q;
   assign dac_code_o = trial;
   assign pwr_en_o   = run_en;
   assign busy_o     = busy;

endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
   parameter int CH_W      = 3,
   parameter int FULL_BITS = 10
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start_i,
   input logic                 idle_i,
   input logic                 idle_pd_i,
   input logic                 busy_o,
   input logic                 done_o,
   input logic [CH_W-1:0]      mux_sel_o,
   input logic [FULL_BITS-1:0] dac_code_o
);

   // R7
   done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && busy_o));

   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);

   // R4
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $fell(busy_o));

   // R6
   mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(mux_sel_o));

   // R9
   gate_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && idle_pd_i && busy_o) |=> $stable(dac_code_o));

   // R9
   gate_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_i && idle_pd_i && !busy_o) |=> !busy_o);

endmodule

bind sar_adc_seq sar_adc_seq_chk #(
   .CH_W     (CH_W),
   .FULL_BITS(FULL_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .idle_i    (idle_i),
   .idle_pd_i (idle_pd_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .mux_sel_o (mux_sel_o),
   .dac_code_o(dac_code_o)
);

// File: tb/sar_adc_seq_bench.sv
module sar_adc_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [2:0] chan_i = 3'd0;
   logic       fast_i = 1'b0;
   logic       idle_i = 1'b0;
   logic       idle_pd_i = 1'b0;
   logic       cmp_i;
   logic [2:0] mux_sel_o;
   logic [9:0] dac_code_o;
   logic       pwr_en_o;
   logic       busy_o;
   logic       done_o;
   logic [7:0] res_hi_o;
   logic [1:0] res_lo_o;

   logic [9:0] ain [8];
   int checks = 0;
   int errors = 0;
   logic [1:0] exp_lo = 2'd0;

   always #2 clk = ~clk;

   // Ideal comparator on the selected input
   assign cmp_i = (ain[mux_sel_o] >= dac_code_o);

   sar_adc_seq u_sar_adc_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .chan_i    (chan_i),
      .fast_i    (fast_i),
      .idle_i    (idle_i),
      .idle_pd_i (idle_pd_i),
      .cmp_i     (cmp_i),
      .mux_sel_o (mux_sel_o),
      .dac_code_o(dac_code_o),
      .pwr_en_o  (pwr_en_o),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .res_hi_o  (res_hi_o),
      .res_lo_o  (res_lo_o)
   );

   // {fast, channel, input level}
   localparam logic [13:0] VEC [10] = '{
      {1'b0, 3'd0, 10'd0},
      {1'b0, 3'd1, 10'd1023},
      {1'b0, 3'd2, 10'h2AB},
      {1'b0, 3'd3, 10'h155},
      {1'b1, 3'd4, 10'h3FF},
      {1'b1, 3'd5, 10'd0},
      {1'b1, 3'd6, 10'h1C7},
      {1'b0, 3'd7, 10'h200},
      {1'b0, 3'd5, 10'h1FF},
      {1'b1, 3'd2, 10'h203}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_conv(input logic m8, input logic [2:0] ch, input logic [9:0] val,
                           input int poke_at, input int gate_at, input int gate_len,
                           input logic idle_on, input string tag);
      int n;
      int bits;
      int cnt;
      int k;
      logic mux_ok;
      logic dac_ok;
      logic pwr_ok;
      n = m8 ? 24 : 50;
      bits = m8 ? 8 : 10;
      for (int i = 0; i < 8; i++) ain[i] = ~val;
      ain[ch] = val;
      idle_i = idle_on;
      idle_pd_i = 1'b0;
      @(negedge clk);
      start_i = 1'b1;
      chan_i = ch;
      fast_i = m8;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1 && done_o === 1'b0, {tag, " R7 start clears done"},
          {busy_o, done_o}, 2'b10);
      cnt = 0;
      k = 1;
      mux_ok = 1'b1;
      dac_ok = 1'b1;
      pwr_ok = 1'b1;
      while (busy_o === 1'b1 && k < 400) begin
         cnt++;
         if (mux_sel_o !== ch) mux_ok = 1'b0;
         if (gate_len == 0) begin
            if (k <= n - bits && dac_code_o !== 10'd0) dac_ok = 1'b0;
            if (k == n - bits + 1 && dac_code_o !== 10'h200) dac_ok = 1'b0;
         end
         if (gate_len > 0 && k > gate_at && k <= gate_at + gate_len && pwr_en_o !== 1'b0)
            pwr_ok = 1'b0;
         if (idle_on && pwr_en_o !== 1'b1) pwr_ok = 1'b0;
         if (k == poke_at) begin
            start_i = 1'b1;
            chan_i = ~ch;
            fast_i = ~m8;
         end
         if (k == poke_at + 1) start_i = 1'b0;
         if (gate_len > 0 && k == gate_at) begin
            idle_i = 1'b1;
            idle_pd_i = 1'b1;
         end
         if (gate_len > 0 && k == gate_at + gate_len) begin
            idle_i = idle_on;
            idle_pd_i = 1'b0;
         end
         @(negedge clk);
         k++;
      end
      chk(cnt == n + gate_len, {tag, " R4 busy length"}, cnt, n + gate_len);
      chk(done_o === 1'b1, {tag, " R4 done at end"}, done_o, 1);
      chk(res_hi_o === val[9:2], {tag, " R2/R3/R11 high field"}, res_hi_o, val[9:2]);
      if (!m8) exp_lo = val[1:0];
      chk(res_lo_o === exp_lo, {tag, " R2/R3 low field"}, res_lo_o, exp_lo);
      chk(mux_ok, {tag, " R6 mux held"}, mux_sel_o, ch);
      if (gate_len == 0) chk(dac_ok, {tag, " R5 settle then MSB first"}, dac_code_o, 0);
      if (gate_len > 0 || idle_on) chk(pwr_ok, {tag, " R9/R10 power enable"}, pwr_en_o, !idle_on);
      chk(pwr_en_o === 1'b1, {tag, " R10 power back"}, pwr_en_o, 1);
      idle_i = 1'b0;
   endtask

   initial begin : wd
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 8; i++) ain[i] = 10'd0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy_o === 1'b0 && done_o === 1'b0, "R1 busy/done", {busy_o, done_o}, 0);
      chk(res_hi_o === 8'd0 && res_lo_o === 2'd0, "R1 results", {res_hi_o, res_lo_o}, 0);
      chk(dac_code_o === 10'd0 && mux_sel_o === 3'd0, "R1 dac/mux", {dac_code_o, mux_sel_o}, 0);
      chk(pwr_en_o === 1'b1, "R1 power", pwr_en_o, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: R2, R3, R11
      for (int v = 0; v < 10; v++) begin
         run_conv(VEC[v][13], VEC[v][12:10], VEC[v][9:0], 0, 0, 0, 1'b0, "vec");
      end

      // R8 / R6: start with other channel and mode during a conversion
      run_conv(1'b0, 3'd3, 10'h2D6, 12, 0, 0, 1'b0, "R8 mid start");
      run_conv(1'b1, 3'd0, 10'h0B5, 5, 0, 0, 1'b0, "R8 mid start fast");

      // R9: power down for 7 cycles in the middle of a conversion
      run_conv(1'b1, 3'd1, 10'h0F3, 0, 5, 7, 1'b0, "R9 frozen");
      run_conv(1'b0, 3'd4, 10'h31E, 0, 44, 3, 1'b0, "R9 frozen in steps");

      // R10: idle without power-down runs normally
      run_conv(1'b0, 3'd6, 10'h17A, 0, 0, 0, 1'b1, "R10 idle active");

      // R7: done persists across quiet cycles
      repeat (5) @(negedge clk);
      chk(done_o === 1'b1, "R7 done held", done_o, 1);

      // R9: start ignored while powered down
      idle_i = 1'b1;
      idle_pd_i = 1'b1;
      @(negedge clk);
      chk(pwr_en_o === 1'b0, "R9 power off", pwr_en_o, 0);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b0, "R9 start ignored busy", busy_o, 0);
      chk(done_o === 1'b1, "R9 start ignored done", done_o, 1);
      idle_i = 1'b0;
      idle_pd_i = 1'b0;
      @(negedge clk);
      chk(busy_o === 1'b0 && res_hi_o === 8'h5E, "R9 nothing launched", {busy_o, res_hi_o}, 8'h5E);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule